// File: doc/BRIEF.md
# Smartcard Convention Character Codec

This block turns data bytes into the sequence of bit slots driven onto a smartcard I/O line, and turns sampled slots back into bytes. A character has DATA_W data slots followed by one parity slot. Two control inputs shape the character. One sets the bit order (least or most significant bit first). The other sets the line polarity (logic 1 driven high, or driven low). With both controls at 0 the codec follows the direct convention. With both at 1 it follows the inverse convention.

Parity is always even, and it is taken over the logical data values before any polarity change. The parity slot is then inverted together with the data slots. Under the inverse convention the logical character therefore still carries an even number of ones.

The surrounding framing logic supplies a bit-tick strobe. On the receive side it also supplies a slot-enable that marks which ticks fall on character slots. Start bits, stop bits, guard time, retransmission after an error signal and clock generation all stay outside this block.

Top module: `sc_conv_codec`

## Requirements
- R1: During and right after a synchronous active-low reset, tx_ready is 1, tx_line is 1, rx_valid is 0 and rx_parity_err is 0.
- R2: With cfg_msb_first=0 and cfg_invert=0, transmitted slot k (k = 0..DATA_W-1) carries tx_data[k] unchanged. Each slot stays on tx_line from the cycle after the previous tick (or after the load) until the tick that ends it.
- R3: With cfg_msb_first=1, transmitted slot k carries data bit DATA_W-1-k.
- R4: With cfg_invert=1, every transmitted slot is the complement of its logical value, and this includes the parity slot.
- R5: The slot after the data slots carries the even-parity bit. That bit is the XOR of the logical data bits, inverted on the line only when cfg_invert=1.
- R6: A character loads on a cycle where tx_valid and tx_ready are both 1. tx_ready then stays 0 until the tick that ends the parity slot. Any tx_valid raised while tx_ready is 0 has no effect on the character in flight.
- R7: The bit order and polarity of a transmitted character are fixed at its load. Changes to the control inputs during the character do not alter it.
- R8: The receiver samples rx_line on each cycle where bit_tick and rx_en are both 1. After DATA_W+1 samples it removes the line inversion, restores the bit order using the control inputs present at the last sample, and shows the byte on rx_data together with a one-cycle rx_valid pulse on the following cycle.
- R9: rx_parity_err pulses together with rx_valid when the XOR of the decoded data bits differs from the logical parity slot. Otherwise it stays 0.
- R10: A tick with rx_en=0 samples nothing and does not advance the receive slot count.
- R11: tx_line rests at 1 whenever no character is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_msb_first | input | 1 | 1: most significant data bit in the first slot |
| cfg_invert | input | 1 | 1: logic 1 driven as low line level |
| bit_tick | input | 1 | One-cycle strobe marking a slot boundary |
| tx_data | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle, able to load a byte |
| tx_line | output | 1 | Transmit slot level |
| rx_en | input | 1 | Current tick falls on a receive character slot |
| rx_line | input | 1 | Receive line level |
| rx_data | output | DATA_W | Decoded received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new byte |
| rx_parity_err | output | 1 | One-cycle pulse: parity of received byte mismatched |

## Verification
The bench builds the codec with the default DATA_W of 8. This width makes the full byte space reachable by random draws, and it fits the 9-slot character the smartcard conventions define. Random bytes run under all four combinations of bit order and polarity, so each control is exercised on its own as well as in the paired inverse setting. Directed cases cover the all-zero and all-one bytes, parity slots corrupted on the line, ticks that fall outside the slot window, load requests made mid-character, and control changes made mid-character.

// File: rtl/sc_conv_pkg.sv
// Package: shared types for the smartcard convention codec.
// Assumes: nothing beyond standard SystemVerilog.
package sc_conv_pkg;
    // Character shaping controls: bit order and line polarity
    typedef struct packed {
        logic msb_first;
        logic invert;
    } sc_cfg_t;
endpackage

// File: rtl/sc_char_encoder.sv
// Module: sc_char_encoder
// Maps a data word to DATA_W+1 line slots. Slot 0 is sent first, and the
// last slot is the even parity. Parity is computed on logical values, and the
// polarity change is applied to every slot afterwards.
// Assumes: purely combinational; the caller registers the result.
module sc_char_encoder
    import sc_conv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  sc_cfg_t           cfg_i,
    output logic [DATA_W:0]   slots_o
);
    logic [DATA_W:0] logical;

    // Pick the data bit for each slot according to the bit order
    for (genvar k = 0; k < DATA_W; k++) begin : g_order
        assign logical[k] = cfg_i.msb_first ? data_i[DATA_W-1-k] : data_i[k];
    end

    // Even parity over the logical data, then polarity applied to all slots
    always_comb begin
        logical[DATA_W] = ^data_i;
        slots_o         = logical ^ {(DATA_W+1){cfg_i.invert}};
    end
endmodule

// File: rtl/sc_char_decoder.sv
// Module: sc_char_decoder
// Reverses the encoder. It first removes the line inversion, then restores
// the bit order, then compares the even parity against the received parity slot.
// Assumes: purely combinational; slot 0 is the first slot received.
module sc_char_decoder
    import sc_conv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W:0]   slots_i,
    input  sc_cfg_t           cfg_i,
    output logic [DATA_W-1:0] data_o,
    output logic              par_err_o
);
    logic [DATA_W:0] logical;

    // Undo polarity first
    assign logical = slots_i ^ {(DATA_W+1){cfg_i.invert}};

    // Undo the bit order
    for (genvar k = 0; k < DATA_W; k++) begin : g_order
        assign data_o[k] = cfg_i.msb_first ? logical[DATA_W-1-k] : logical[k];
    end

    // Mismatch between recomputed and received parity
    assign par_err_o = (^data_o) != logical[DATA_W];
endmodule

// File: rtl/sc_tx_shifter.sv
// Module: sc_tx_shifter
// Holds one encoded character and presents one slot at a time on the line.
// Each bit tick moves on to the next slot. The line rests high when idle.
// Assumes: a load is only accepted while idle; the slots are already encoded.
module sc_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [DATA_W:0] slots_i,
    input  logic            bit_tick,
    output logic            busy_o,
    output logic            line_o
);
    localparam int              CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    logic [DATA_W:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic             busy;

    // Load a character, then shift one slot per tick until the parity slot ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            shreg <= '1;
        end else if (!busy) begin
            if (load_i) begin
                busy  <= 1'b1;
                cnt   <= '0;
                shreg <= slots_i;
            end
        end else if (bit_tick) begin
            if (cnt == LAST) begin
                busy  <= 1'b0;
                cnt   <= '0;
                shreg <= '1;
            end else begin
                cnt   <= cnt + 1'b1;
                shreg <= {1'b1, shreg[DATA_W:1]};
            end
        end
    end

    assign busy_o = busy;
    assign line_o = busy ? shreg[0] : 1'b1;

    // Between ticks the slot in flight must not move
    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> ($stable(shreg) && $stable(cnt)));

    // The slot counter never passes the parity slot
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/sc_rx_collector.sv
// Module: sc_rx_collector
// Gathers line samples taken on ticks that fall inside the slot window.
// On the final slot it presents the whole character together with a done strobe.
// Assumes: the framing logic raises slot_en only on character slots.
module sc_rx_collector #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            slot_en,
    input  logic            line_i,
    output logic            done_o,
    output logic [DATA_W:0] slots_o
);
    localparam int              CNT_W = $clog2(DATA_W + 1);
    localparam int              IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              take;

    assign take = bit_tick && slot_en;

    // Store each sampled data slot by its position and wrap after the parity slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (take) begin
            if (cnt == LAST) begin
                cnt <= '0;
            end else begin
                cnt                 <= cnt + 1'b1;
                shreg[cnt[IDX_W-1:0]] <= line_i;
            end
        end
    end

    assign done_o  = take && (cnt == LAST);
    assign slots_o = {line_i, shreg};

    // Ticks outside the slot window leave the count untouched
    assert_skip_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cnt));
endmodule

// File: rtl/sc_conv_codec.sv
// Module: sc_conv_codec (top)
// Smartcard character codec for the direct and inverse conventions. The
// transmitter encodes the byte at load, so its controls are fixed for the
// whole character. The receiver decodes with the controls present at the last slot.
// Assumes: bit_tick is a one-cycle strobe; framing is handled outside.
module sc_conv_codec
    import sc_conv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    input  logic              rx_en,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err
);
    sc_cfg_t           cfg;
    logic [DATA_W:0]   tx_slots;
    logic              tx_busy;
    logic              rx_done;
    logic [DATA_W:0]   rx_slots;
    logic [DATA_W-1:0] dec_data;
    logic              dec_err;

    assign cfg = '{msb_first: cfg_msb_first, invert: cfg_invert};

    sc_char_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i  (tx_data),
        .cfg_i   (cfg),
        .slots_o (tx_slots)
    );

    sc_tx_shifter #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tx_valid),
        .slots_i  (tx_slots),
        .bit_tick (bit_tick),
        .busy_o   (tx_busy),
        .line_o   (tx_line)
    );

    assign tx_ready = !tx_busy;

    sc_rx_collector #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .slot_en  (rx_en),
        .line_i   (rx_line),
        .done_o   (rx_done),
        .slots_o  (rx_slots)
    );

    sc_char_decoder #(.DATA_W(DATA_W)) u_dec (
        .slots_i   (rx_slots),
        .cfg_i     (cfg),
        .data_o    (dec_data),
        .par_err_o (dec_err)
    );

    // Register the decoded byte and raise one-cycle valid and error strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data       <= '0;
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
        end else begin
            rx_valid      <= rx_done;
            rx_parity_err <= rx_done && dec_err;
            if (rx_done) begin
                rx_data <= dec_data;
            end
        end
    end

    // An accepted load makes the transmitter busy on the next cycle
    assert_load_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // A character needs several slots, so valid never repeats on back-to-back cycles
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // A parity error is only reported together with a received byte
    assert_err_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_parity_err |-> rx_valid);
endmodule

// File: tb/tb_sc_conv_codec.sv
// Bench for sc_conv_codec: seeded random bytes and controls plus directed corners.
module tb_sc_conv_codec;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_msb_first = 1'b0;
    logic         cfg_invert = 1'b0;
    logic         bit_tick = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic         tx_line;
    logic         rx_en = 1'b0;
    logic         rx_line = 1'b1;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic         rx_parity_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sc_conv_codec #(.DATA_W(W)) dut (.*);

    // Expected slot sequence per R2..R5
    function automatic logic [W:0] exp_slots(input logic [W-1:0] d, input logic msb, input logic inv);
        logic [W:0] s;
        for (int k = 0; k < W; k++) s[k] = msb ? d[W-1-k] : d[k];
        s[W] = ^d;
        return s ^ {(W+1){inv}};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Transmit one byte and compare the slots seen on tx_line
    task automatic send_tx(input logic [W-1:0] d, input logic msb, input logic inv,
                           input bit poke_valid, input bit flip_cfg, input string req);
        logic [W:0] got;
        logic [W:0] expv;
        expv = exp_slots(d, msb, inv);
        @(negedge clk);
        cfg_msb_first = msb; cfg_invert = inv;
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R6 busy after load", tx_ready, 0);
        for (int k = 0; k <= W; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            got[k] = tx_line;
            if (k == 4 && poke_valid) begin tx_data = ~d; tx_valid = 1'b1; end
            if (k == 4 && flip_cfg) begin cfg_msb_first = ~msb; cfg_invert = ~inv; end
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            tx_valid = 1'b0;
        end
        check(got == expv, req, got, expv);
        check(tx_ready == 1'b1 && tx_line == 1'b1, "R11 idle after character",
              {tx_ready, tx_line}, 3);
    endtask

    // Drive one received character, optionally with a bad parity slot or a stray tick
    task automatic send_rx(input logic [W-1:0] d, input logic msb, input logic inv,
                           input bit bad_par, input bit stray, input string req);
        logic [W:0] s;
        s = exp_slots(d, msb, inv);
        if (bad_par) s[W] = ~s[W];
        @(negedge clk);
        cfg_msb_first = msb; cfg_invert = inv;
        for (int k = 0; k <= W; k++) begin
            if (stray && k == 3) begin
                rx_en = 1'b0; rx_line = ~s[k]; bit_tick = 1'b1;
                @(negedge clk);
                bit_tick = 1'b0;
            end
            rx_en = 1'b1; rx_line = s[k]; bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0; rx_en = 1'b0;
            if (k < W) check(rx_valid == 1'b0, "R10 no early valid", rx_valid, 0);
        end
        check(rx_valid == 1'b1 && rx_data == d, req, {rx_valid, rx_data}, {1'b1, d});
        check(rx_parity_err == bad_par, "R9 parity flag", rx_parity_err, bad_par);
        @(negedge clk);
        check(rx_valid == 1'b0 && rx_parity_err == 1'b0, "R8 one-cycle pulse",
              {rx_valid, rx_parity_err}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tx_ready && tx_line && !rx_valid && !rx_parity_err, "R1 reset state",
              {tx_ready, tx_line, rx_valid, rx_parity_err}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready && tx_line && !rx_valid && !rx_parity_err, "R1 after release",
              {tx_ready, tx_line, rx_valid, rx_parity_err}, 4'b1100);

        // Directed corners
        send_tx(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R2 direct lsb first");
        send_tx(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, "R3 msb first order");
        send_tx(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R4 inverted zero byte");
        send_tx(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, "R5 inverse all ones parity");
        send_tx(8'h07, 1'b0, 1'b0, 1'b0, 1'b0, "R5 odd weight parity");
        send_tx(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, "R6 load ignored while busy");
        send_tx(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, "R7 cfg change mid character");
        send_rx(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "R8 direct receive");
        send_rx(8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, "R8 inverse receive");
        send_rx(8'h81, 1'b1, 1'b1, 1'b1, 1'b0, "R9 bad parity inverse");
        send_rx(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R9 bad parity direct");
        send_rx(8'h6E, 1'b0, 1'b1, 1'b0, 1'b1, "R10 stray tick skipped");

        // Seeded random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 40; i++) begin
            send_tx(W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0,
                    "R2 R3 R4 R5 random transmit");
            send_rx(W'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                    ($urandom % 4) == 0, "R8 random receive");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule